// File: doc/BRIEF.md
# Multi-source configurable GPIO port

This block is one bidirectional I/O port whose pins are configured one at a time from a microcontroller register bus. A per-pin output multiplexer picks what each pin drives. It can drive the data-out register bit, a bit of an address word held by an address-latch-enable strobe, a logic-macrocell output, or one of two external chip-select lines. The pin's driver enable comes from a direction register. Pins named in a build-time mask take it from an external enable term instead. The block provides the driven value and the enable per pin, and the pad's tri-state buffer uses them.

A single read-back path puts exactly one source on the bus read data. The bus offset selects it: the synchronized pin state, the data-out register, the direction register, the select (control) register or the macrocell outputs. The synchronized pin state also goes to the macrocell logic. The port width is a parameter, so a narrow three-pin build is one setting. A build without the control register fixes every pin's source with a parameter.

Top module: `mux_gpio_port`

## Requirements
- R1: After reset the data-out, direction and control registers are 0. Every pin then has its enable low and selects the data-out source.
- R2: A bus write at offset 1 loads the data-out register from bus_wdata[PW-1:0] on that clock edge, and a read at offset 1 returns it.
- R3: For a pin whose OE_TERM_MASK bit is 0, pin_oe equals its direction bit. Direction is written at offset 2, where 1 drives and 0 tri-states.
- R4: The control register is written at offset 3 and holds a 2-bit select per pin i in bits [2i+1:2i]. The select values are 0 for data-out, 1 for latched address, 2 for macrocell output and 3 for chip-select, and pin_out follows the selected source in the same cycle.
- R5: A pin i with select 3 drives ext_cs[i mod 2].
- R6: The address latch loads addr_in on every clock edge where ale is 1 and holds its value while ale is 0.
- R7: A read at offset 0, and the mc_pin_in output, give pin_in delayed by two clock edges.
- R8: bus_rdata is combinational on bus_off. Offset 2 returns the direction register, offset 3 the control register and offset 4 the current mc_out. Offsets 5 to 7 return 0.
- R9: For a pin whose OE_TERM_MASK bit is 1, pin_oe follows oe_term and ignores the direction register.
- R10: A write at offset 0, 4, 5, 6 or 7 changes none of the data-out, direction or control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_off | input | 3 | Register offset for write and read-back |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 2*PW | Write data |
| bus_rdata | output | 2*PW | Read-back data for bus_off |
| ale | input | 1 | Address latch enable |
| addr_in | input | PW | Address bits offered to the latch |
| mc_out | input | PW | Macrocell outputs |
| ext_cs | input | 2 | External chip-select lines |
| oe_term | input | PW | External output-enable terms |
| pin_in | input | PW | Raw pad input levels |
| pin_out | output | PW | Value each pin drives |
| pin_oe | output | PW | Driver enable per pin |
| mc_pin_in | output | PW | Synchronized pin state for the macrocells |

## Verification
pin_out, pin_oe and bus_rdata are combinational, so their result is due in the same cycle as the inputs that feed them. Register writes and the address latch take effect one clock edge after their strobe. Pin state reaches the read-back and mc_pin_in two edges after the pin changes. The bench drives every input on the falling edge and checks the combinational outputs a moment later against a model that holds the state from before the edge. Only then does it let the rising edge pass and advance the model, so each result is compared in exactly the cycle in which it is due.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int OFF_W  = 3;
   localparam int NUM_CS = 2;

   typedef enum logic [OFF_W-1:0] {
      OFF_PINS  = 3'd0,
      OFF_DOUT  = 3'd1,
      OFF_DIR   = 3'd2,
      OFF_CTRL  = 3'd3,
      OFF_MCELL = 3'd4
   } reg_off_e;

   typedef enum logic [1:0] {
      SRC_DOUT  = 2'd0,
      SRC_ADDR  = 2'd1,
      SRC_MCELL = 2'd2,
      SRC_CS    = 2'd3
   } out_src_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int          PW        = 8,
   parameter bit          HAS_CTRL  = 1'b1,
   parameter logic [2*PW-1:0] FIXED_SEL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [OFF_W-1:0]  off,
   input  logic [2*PW-1:0]   wdata,
   output logic [PW-1:0]     dout,
   output logic [PW-1:0]     dir,
   output logic [2*PW-1:0]   ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         dir  <= '0;
      end else if (wr) begin
         if (off == OFF_DOUT) dout <= wdata[PW-1:0];
         if (off == OFF_DIR)  dir  <= wdata[PW-1:0];
      end
   end

   generate
      if (HAS_CTRL) begin : g_ctrl_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          ctrl <= '0;
            else if (wr && off == OFF_CTRL)      ctrl <= wdata;
         end
      end else begin : g_ctrl_fixed
         assign ctrl = FIXED_SEL;
      end
   endgenerate
endmodule

// File: rtl/gpio_addr_latch.sv
module gpio_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] addr_in,
   output logic [W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr_q <= '0;
      else if (ale) addr_q <= addr_in;
   end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/gpio_out_slice.sv
module gpio_out_slice
   import gpio_pkg::*;
#(
   parameter bit OE_FROM_TERM = 1'b0
) (
   input  logic [1:0] sel,
   input  logic       dout_b,
   input  logic       addr_b,
   input  logic       mc_b,
   input  logic       cs_b,
   input  logic       dir_b,
   input  logic       oe_term_b,
   output logic       out_b,
   output logic       oe_b
);
   always_comb begin
      unique case (out_src_e'(sel))
         SRC_DOUT:  out_b = dout_b;
         SRC_ADDR:  out_b = addr_b;
         SRC_MCELL: out_b = mc_b;
         SRC_CS:    out_b = cs_b;
         default:   out_b = dout_b;
      endcase
   end

   assign oe_b = OE_FROM_TERM ? oe_term_b : dir_b;
endmodule

// File: rtl/mux_gpio_port.sv
module mux_gpio_port
   import gpio_pkg::*;
#(
   parameter int              PW           = 8,
   parameter bit              HAS_CTRL     = 1'b1,
   parameter logic [2*PW-1:0] FIXED_SEL    = '0,
   parameter logic [PW-1:0]   OE_TERM_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_off,
   input  logic              bus_wr,
   input  logic [2*PW-1:0]   bus_wdata,
   output logic [2*PW-1:0]   bus_rdata,
   input  logic              ale,
   input  logic [PW-1:0]     addr_in,
   input  logic [PW-1:0]     mc_out,
   input  logic [1:0]        ext_cs,
   input  logic [PW-1:0]     oe_term,
   input  logic [PW-1:0]     pin_in,
   output logic [PW-1:0]     pin_out,
   output logic [PW-1:0]     pin_oe,
   output logic [PW-1:0]     mc_pin_in
);
   localparam int BUS_W = 2 * PW;

   generate
      if (PW < 1 || PW > 16) begin : g_bad_width
         $error("mux_gpio_port: PW must lie in 1..16");
      end
   endgenerate

   logic [PW-1:0]    dout_r;
   logic [PW-1:0]    dir_r;
   logic [BUS_W-1:0] ctrl_r;
   logic [PW-1:0]    alat_r;
   logic [PW-1:0]    pin_sync;

   gpio_regfile #(.PW(PW), .HAS_CTRL(HAS_CTRL), .FIXED_SEL(FIXED_SEL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .off(bus_off), .wdata(bus_wdata),
      .dout(dout_r), .dir(dir_r), .ctrl(ctrl_r)
   );

   gpio_addr_latch #(.W(PW)) u_alat (
      .clk(clk), .rst_n(rst_n), .ale(ale), .addr_in(addr_in), .addr_q(alat_r)
   );

   gpio_sync2 #(.W(PW)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   assign mc_pin_in = pin_sync;

   generate
      for (genvar i = 0; i < PW; i++) begin : g_pin
         gpio_out_slice #(.OE_FROM_TERM(OE_TERM_MASK[i])) u_slice (
            .sel       (ctrl_r[2*i +: 2]),
            .dout_b    (dout_r[i]),
            .addr_b    (alat_r[i]),
            .mc_b      (mc_out[i]),
            .cs_b      (ext_cs[i % NUM_CS]),
            .dir_b     (dir_r[i]),
            .oe_term_b (oe_term[i]),
            .out_b     (pin_out[i]),
            .oe_b      (pin_oe[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (bus_off)
         OFF_PINS:  bus_rdata[PW-1:0] = pin_sync;
         OFF_DOUT:  bus_rdata[PW-1:0] = dout_r;
         OFF_DIR:   bus_rdata[PW-1:0] = dir_r;
         OFF_CTRL:  bus_rdata         = HAS_CTRL ? ctrl_r : '0;
         OFF_MCELL: bus_rdata[PW-1:0] = mc_out;
         default:   bus_rdata         = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
   import gpio_pkg::*;
#(
   parameter int            PW           = 8,
   parameter logic [PW-1:0] OE_TERM_MASK = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic [2:0]      bus_off,
   input logic [2*PW-1:0] bus_wdata,
   input logic [2*PW-1:0] bus_rdata,
   input logic            ale,
   input logic [PW-1:0]   addr_in,
   input logic [PW-1:0]   oe_term,
   input logic [PW-1:0]   pin_in,
   input logic [PW-1:0]   pin_oe,
   input logic [PW-1:0]   mc_pin_in,
   input logic [PW-1:0]   dout_q,
   input logic [PW-1:0]   dir_q,
   input logic [2*PW-1:0] ctrl_q,
   input logic [PW-1:0]   alat_q
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dout_q == '0 && dir_q == '0));

   a_r2_dout_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_off == OFF_DOUT) |=> dout_q == $past(bus_wdata[PW-1:0]));

   a_r6_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> alat_q == $past(addr_in));

   a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> $stable(alat_q));

   a_r7_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> mc_pin_in == $past(pin_in, 2));

   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_off > 3'd4) |-> bus_rdata == '0);

   a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_off == OFF_PINS || bus_off >= OFF_MCELL))
      |=> ($stable(dout_q) && $stable(dir_q) && $stable(ctrl_q)));

   generate
      for (genvar i = 0; i < PW; i++) begin : g_oe_chk
         if (OE_TERM_MASK[i]) begin : g_term
            a_r9_oe_term: assert property (@(posedge clk) disable iff (!rst_n)
               pin_oe[i] == oe_term[i]);
         end else begin : g_dir
            a_r3_oe_dir: assert property (@(posedge clk) disable iff (!rst_n)
               pin_oe[i] == dir_q[i]);
         end
      end
   endgenerate
endmodule

bind mux_gpio_port gpio_port_checker #(.PW(PW), .OE_TERM_MASK(OE_TERM_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_off(bus_off),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ale(ale), .addr_in(addr_in),
   .oe_term(oe_term), .pin_in(pin_in), .pin_oe(pin_oe), .mc_pin_in(mc_pin_in),
   .dout_q(dout_r), .dir_q(dir_r), .ctrl_q(ctrl_r), .alat_q(alat_r)
);

// File: tb/mux_gpio_port_test.sv
`timescale 1ns/1ps
module mux_gpio_port_test;
   localparam int            PW   = 8;
   localparam logic [PW-1:0] MASK = 8'hC0;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      bus_off = '0;
   logic            bus_wr = 1'b0;
   logic [2*PW-1:0] bus_wdata = '0;
   logic [2*PW-1:0] bus_rdata;
   logic            ale = 1'b0;
   logic [PW-1:0]   addr_in = '0, mc_out = '0, oe_term = '0, pin_in = '0;
   logic [1:0]      ext_cs = '0;
   logic [PW-1:0]   pin_out, pin_oe, mc_pin_in;

   always #5 clk = ~clk;

   mux_gpio_port #(.PW(PW), .HAS_CTRL(1'b1), .OE_TERM_MASK(MASK)) uut (
      .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ale(ale), .addr_in(addr_in),
      .mc_out(mc_out), .ext_cs(ext_cs), .oe_term(oe_term), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .mc_pin_in(mc_pin_in)
   );

   // reference model state
   logic [PW-1:0]   m_dout = '0, m_dir = '0, m_alat = '0, m_s1 = '0, m_s2 = '0;
   logic [2*PW-1:0] m_ctrl = '0;
   int vectors = 0, fails = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [PW-1:0] exp_out();
      logic [PW-1:0] r;
      for (int i = 0; i < PW; i++) begin
         case (m_ctrl[2*i +: 2])
            2'd0: r[i] = m_dout[i];
            2'd1: r[i] = m_alat[i];
            2'd2: r[i] = mc_out[i];
            default: r[i] = ext_cs[i % 2];
         endcase
      end
      return r;
   endfunction

   function automatic logic [PW-1:0] exp_oe();
      return (MASK & oe_term) | (~MASK & m_dir);
   endfunction

   function automatic logic [2*PW-1:0] exp_rd();
      case (bus_off)
         3'd0: return {{PW{1'b0}}, m_s2};
         3'd1: return {{PW{1'b0}}, m_dout};
         3'd2: return {{PW{1'b0}}, m_dir};
         3'd3: return m_ctrl;
         3'd4: return {{PW{1'b0}}, mc_out};
         default: return '0;
      endcase
   endfunction

   // check combinational outputs, then pass one rising edge
   task automatic cycle();
      #1;
      chk("R4", 16'(pin_out),   16'(exp_out()));
      chk("R3", 16'(pin_oe),    16'(exp_oe()));
      chk("R8", bus_rdata,      exp_rd());
      chk("R7", 16'(mc_pin_in), 16'(m_s2));
      @(posedge clk);
      if (bus_wr) begin
         if (bus_off == 3'd1) m_dout = bus_wdata[PW-1:0];
         if (bus_off == 3'd2) m_dir  = bus_wdata[PW-1:0];
         if (bus_off == 3'd3) m_ctrl = bus_wdata;
      end
      if (ale) m_alat = addr_in;
      m_s2 = m_s1;
      m_s1 = pin_in;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] off, input logic [15:0] d);
      bus_wr = 1'b1; bus_off = off; bus_wdata = d;
      cycle();
      bus_wr = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1: reset state
      mc_out = 8'hFF; ext_cs = 2'b11; bus_off = 3'd1;
      #1;
      chk("R1", 16'(pin_oe), 16'h0000);
      chk("R1", 16'(pin_out), 16'h0000);
      chk("R1", bus_rdata, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      cycle();

      // R2: data-out write and read-back
      wr(3'd1, 16'h00A5);
      bus_off = 3'd1; #1; chk("R2", bus_rdata, 16'h00A5);
      // R3: direction drives pins without term mask
      wr(3'd2, 16'h00FF);
      oe_term = 8'h00; #1; chk("R3", 16'(pin_oe), 16'h003F);
      // R9: masked pins follow oe_term, ignore direction
      wr(3'd2, 16'h0000);
      oe_term = 8'hFF; #1; chk("R9", 16'(pin_oe), 16'h00C0);
      // R5: chip-select per pin parity
      wr(3'd3, 16'hFFFF);
      ext_cs = 2'b01; #1; chk("R5", 16'(pin_out), 16'h0055);
      ext_cs = 2'b10; #1; chk("R5", 16'(pin_out), 16'h00AA);
      // R4: macrocell source
      wr(3'd3, 16'hAAAA);
      mc_out = 8'h96; #1; chk("R4", 16'(pin_out), 16'h0096);
      // R6: address latch load and hold
      wr(3'd3, 16'h5555);
      ale = 1'b1; addr_in = 8'h3C; cycle();
      ale = 1'b0; addr_in = 8'hFF; cycle();
      chk("R6", 16'(pin_out), 16'h003C);
      // R7: two-edge pin synchronizer
      pin_in = 8'h00; cycle(); cycle();
      pin_in = 8'h5A; bus_off = 3'd0; cycle();
      #1; chk("R7", bus_rdata, 16'h0000);
      cycle();
      chk("R7", bus_rdata, 16'h005A);
      // R8: unmapped offset and macrocell read
      bus_off = 3'd6; #1; chk("R8", bus_rdata, 16'h0000);
      bus_off = 3'd4; mc_out = 8'h3E; #1; chk("R8", bus_rdata, 16'h003E);
      // R10: writes to non-register offsets are ignored
      wr(3'd0, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'hFFFF); wr(3'd7, 16'hFFFF);
      bus_off = 3'd1; #1; chk("R10", bus_rdata, 16'h00A5);
      bus_off = 3'd3; #1; chk("R10", bus_rdata, 16'h5555);

      // constrained random phase
      for (int n = 0; n < 3000; n++) begin
         bus_wr    = ($urandom_range(0, 3) == 0);
         bus_off   = 3'($urandom_range(0, 7));
         bus_wdata = 16'($urandom);
         ale       = ($urandom_range(0, 2) == 0);
         addr_in   = 8'($urandom);
         mc_out    = 8'($urandom);
         ext_cs    = 2'($urandom);
         oe_term   = 8'($urandom);
         pin_in    = 8'($urandom);
         cycle();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule